// File: doc/BRIEF.md
# Per-Destination Cell Queue with Whole-Packet Admission

This block sits on the ingress side of one port of an input-queued cell switch. Packets arrive already cut into cells, at most one cell per clock (one clock stands for one slot). Each cell carries a destination output, a start-of-packet marker, an end-of-packet marker, the packet length in cells and a data word. The block keeps one bounded FIFO per destination output, so a cell blocked on one output never holds back cells for another. No buffer space is shared between queues.

The block decides admission once per packet, on its first cell. It accepts the packet only if the destination queue has free space for every one of its cells. If it does not, the block discards the whole packet, so a fragment never enters the fabric. The cells of an accepted packet land back to back in one queue. The external scheduler reads per-queue occupancy and empty flags and picks one queue per slot to dequeue. The block returns that queue's head cell one clock later, with its start marker and length so the scheduler can see where packets begin.

Admission is a three-state machine. IDLE waits for a first cell. PASS writes the remaining cells of an accepted packet into the queue latched at its first cell. DROP swallows the remaining cells of a rejected packet. The transitions are as follows:
- A first cell that fits and is also last goes to IDLE.
- A first cell that fits and is not last goes to PASS.
- A first cell that does not fit goes to DROP, unless it is also last, in which case it goes to IDLE.
- A last cell in PASS or DROP returns to IDLE.
- A new first cell in any state starts a fresh decision.

Top module: `voq_buffer`

## Requirements
- R1: After reset every queue count is 0, every empty flag is 1, and both `out_valid` and `deq_err` are 0.
- R2: A cell with `in_sop`=1 is accepted, and raises its queue's count by 1 after the next clock edge, exactly when 1 <= `in_len` <= DEPTH minus that queue's count in the same cycle.
- R3: When a packet is rejected, its first cell and every later cell up to and including the one with `in_eop`=1 leave every queue count unchanged.
- R4: The non-first cells of an accepted packet go into the queue chosen at its first cell, whatever `in_dest` they carry.
- R5: No queue ever holds more than DEPTH cells. Filling one queue changes neither the count nor the admission of any other queue.
- R6: A dequeue request to a non-empty queue makes `out_valid`=1 after the next edge. The output then carries that queue's oldest cell (data, start marker, length) and the queue's count drops by 1. Cells leave each queue in arrival order.
- R7: A dequeue request to an empty queue gives `out_valid`=0 and `deq_err`=1 for one cycle after the next edge, and leaves every count unchanged.
- R8: An accepted cell and a dequeue on the same queue in one cycle both take effect, and that queue's count stays the same.
- R9: Each empty flag is 1 exactly when the matching count is 0.
- R10: A cell without `in_sop` that arrives in IDLE is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An arriving cell is present |
| in_sop | input | 1 | Cell is the first of its packet |
| in_eop | input | 1 | Cell is the last of its packet |
| in_dest | input | DEST_W | Destination output of the packet (used on the first cell) |
| in_len | input | LEN_W | Packet length in cells |
| in_data | input | DATA_W | Cell payload |
| deq_valid | input | 1 | Scheduler asks for one cell this slot |
| deq_sel | input | DEST_W | Queue to dequeue from |
| out_valid | output | 1 | Dequeued cell valid |
| out_sop | output | 1 | Start marker of the dequeued cell |
| out_len | output | LEN_W | Length field of the dequeued cell |
| out_data | output | DATA_W | Payload of the dequeued cell |
| deq_err | output | 1 | Previous dequeue named an empty queue |
| occ_flat | output | NUM_OUT*CNT_W | Per-queue cell counts, queue i at bits [i*CNT_W +: CNT_W] |
| empty_vec | output | NUM_OUT | Per-queue empty flags |

## Verification
A wrong admission state shows up on the ports within one clock. After a rejected first cell that should have gone to DROP, the trailing cells raise some count on the next edge. A PASS state that wrongly falls back to IDLE leaves a count short by the rest of the packet once the last cell has gone. A wrong latched destination moves cells into another queue's count, and later dequeues then return the wrong payload sequence. Pointer or count faults in a queue appear as wrong data, a wrong start marker or a false `deq_err` on the first dequeue after the fault.

// File: rtl/voq_pkg.sv
package voq_pkg;

    typedef enum logic [1:0] {
        ADM_IDLE = 2'd0,
        ADM_PASS = 2'd1,
        ADM_DROP = 2'd2
    } adm_state_t;

endpackage

// File: rtl/voq_fifo.sv
module voq_fifo #(
    parameter int DEPTH  = 8,
    parameter int CELL_W = 17,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CELL_W-1:0] wr_cell,
    input  logic              rd_en,
    output logic [CELL_W-1:0] rd_cell,
    output logic [CNT_W-1:0]  count,
    output logic              empty
);

    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    logic [CELL_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_ptr] <= wr_cell;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_en) begin
                wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            end
            if (rd_en) begin
                rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
            end
            case ({wr_en, rd_en})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign rd_cell = mem[rd_ptr];
    assign empty   = (count == '0);

    // R5: a write without a read never lands on a full queue
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en) |-> (count != CNT_W'(DEPTH)));

    // R7: reads are never issued to an empty queue
    p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (count != '0));

    // R9: draining the last cell raises the empty flag
    p_empty_after_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && count == CNT_W'(1)) |=> empty);

endmodule

// File: rtl/voq_admit_fsm.sv
module voq_admit_fsm
    import voq_pkg::*;
#(
    parameter int NUM_OUT = 4,
    parameter int DEPTH   = 8,
    parameter int LEN_W   = 8,
    localparam int DEST_W = $clog2(NUM_OUT),
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int CMP_W  = ((LEN_W > CNT_W) ? LEN_W : CNT_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [DEST_W-1:0] in_dest,
    input  logic [LEN_W-1:0]  in_len,
    input  logic [CNT_W-1:0]  sel_cnt,
    output logic              wr_en,
    output logic [DEST_W-1:0] wr_dest
);

    adm_state_t        state_q, state_d;
    logic [DEST_W-1:0] dest_q;
    logic [CMP_W-1:0]  room;
    logic [CMP_W-1:0]  need;
    logic              fits;

    assign room = CMP_W'(DEPTH) - CMP_W'(sel_cnt);
    assign need = CMP_W'(in_len);
    assign fits = (need != '0) && (need <= room);

    // state register and latched destination
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ADM_IDLE;
            dest_q  <= '0;
        end else begin
            state_q <= state_d;
            if (in_valid && in_sop) begin
                dest_q <= in_dest;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (in_valid) begin
            if (in_sop) begin
                if (in_eop)    state_d = ADM_IDLE;
                else if (fits) state_d = ADM_PASS;
                else           state_d = ADM_DROP;
            end else begin
                unique case (state_q)
                    ADM_IDLE: state_d = ADM_IDLE;
                    ADM_PASS: state_d = in_eop ? ADM_IDLE : ADM_PASS;
                    ADM_DROP: state_d = in_eop ? ADM_IDLE : ADM_DROP;
                    default:  state_d = ADM_IDLE;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        wr_en   = 1'b0;
        wr_dest = dest_q;
        if (in_valid) begin
            if (in_sop) begin
                wr_dest = in_dest;
                wr_en   = fits;
            end else begin
                unique case (state_q)
                    ADM_PASS: wr_en = 1'b1;
                    ADM_IDLE: wr_en = 1'b0;
                    ADM_DROP: wr_en = 1'b0;
                    default:  wr_en = 1'b0;
                endcase
            end
        end
    end

    // R3: no continuation cell is written while swallowing a packet
    p_drop_swallows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ADM_DROP && in_valid && !in_sop) |-> !wr_en);

    // R10: a stray continuation cell in IDLE is never written
    p_idle_stray_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ADM_IDLE && !in_sop) |-> !wr_en);

    // R4: continuation cells keep the destination of their first cell
    p_latched_dest_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sop && wr_en && !in_eop) |=>
            (state_q == ADM_PASS && wr_dest == $past(in_dest)));

endmodule

// File: rtl/voq_buffer.sv
module voq_buffer #(
    parameter int NUM_OUT = 4,
    parameter int DEPTH   = 8,
    parameter int LEN_W   = 8,
    parameter int DATA_W  = 8,
    localparam int DEST_W = $clog2(NUM_OUT),
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int CELL_W = 1 + LEN_W + DATA_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic                     in_sop,
    input  logic                     in_eop,
    input  logic [DEST_W-1:0]        in_dest,
    input  logic [LEN_W-1:0]         in_len,
    input  logic [DATA_W-1:0]        in_data,
    input  logic                     deq_valid,
    input  logic [DEST_W-1:0]        deq_sel,
    output logic                     out_valid,
    output logic                     out_sop,
    output logic [LEN_W-1:0]         out_len,
    output logic [DATA_W-1:0]        out_data,
    output logic                     deq_err,
    output logic [NUM_OUT*CNT_W-1:0] occ_flat,
    output logic [NUM_OUT-1:0]       empty_vec
);

    logic [CNT_W-1:0]  cnt      [NUM_OUT];
    logic [CELL_W-1:0] rd_cells [NUM_OUT];
    logic [NUM_OUT-1:0] wr_vec;
    logic [NUM_OUT-1:0] rd_vec;
    logic              adm_wr;
    logic [DEST_W-1:0] adm_dest;
    logic              rd_ok;
    logic              sel_empty;
    logic [CELL_W-1:0] head_cell;
    logic [CELL_W-1:0] out_cell_q;

    voq_admit_fsm #(
        .NUM_OUT (NUM_OUT),
        .DEPTH   (DEPTH),
        .LEN_W   (LEN_W)
    ) u_admit (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sop   (in_sop),
        .in_eop   (in_eop),
        .in_dest  (in_dest),
        .in_len   (in_len),
        .sel_cnt  (cnt[in_dest]),
        .wr_en    (adm_wr),
        .wr_dest  (adm_dest)
    );

    assign sel_empty = empty_vec[deq_sel];
    assign rd_ok     = deq_valid && !sel_empty;

    for (genvar q = 0; q < NUM_OUT; q++) begin : g_queue
        assign wr_vec[q] = adm_wr && (adm_dest == DEST_W'(q));
        assign rd_vec[q] = rd_ok && (deq_sel == DEST_W'(q));

        voq_fifo #(
            .DEPTH  (DEPTH),
            .CELL_W (CELL_W)
        ) u_fifo (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_vec[q]),
            .wr_cell ({in_sop, in_len, in_data}),
            .rd_en   (rd_vec[q]),
            .rd_cell (rd_cells[q]),
            .count   (cnt[q]),
            .empty   (empty_vec[q])
        );

        assign occ_flat[q*CNT_W +: CNT_W] = cnt[q];
    end

    assign head_cell = rd_cells[deq_sel];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            deq_err    <= 1'b0;
            out_cell_q <= '0;
        end else begin
            out_valid <= rd_ok;
            deq_err   <= deq_valid && sel_empty;
            if (rd_ok) begin
                out_cell_q <= head_cell;
            end
        end
    end

    assign out_sop  = out_cell_q[CELL_W-1];
    assign out_len  = out_cell_q[DATA_W +: LEN_W];
    assign out_data = out_cell_q[DATA_W-1:0];

    // R7: dequeue of an empty queue flags an error and yields no cell
    p_empty_deq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (deq_valid && sel_empty) |=> (deq_err && !out_valid));

    // R6: a granted dequeue always produces a cell
    p_deq_yields_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (deq_valid && !sel_empty) |=> (out_valid && !deq_err));

    // R5: at most one queue written per slot
    p_one_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_vec));

endmodule

// File: tb/tb_voq_buffer.sv
module tb_voq_buffer;

    localparam int CLK_PERIOD = 10;
    localparam int NO     = 4;
    localparam int DP     = 8;
    localparam int LW     = 8;
    localparam int DW     = 8;
    localparam int DEST_W = $clog2(NO);
    localparam int CNT_W  = $clog2(DP + 1);
    localparam int MQ     = 64;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              in_valid, in_sop, in_eop;
    logic [DEST_W-1:0] in_dest;
    logic [LW-1:0]     in_len;
    logic [DW-1:0]     in_data;
    logic              deq_valid;
    logic [DEST_W-1:0] deq_sel;
    logic              out_valid, out_sop, deq_err;
    logic [LW-1:0]     out_len;
    logic [DW-1:0]     out_data;
    logic [NO*CNT_W-1:0] occ_flat;
    logic [NO-1:0]     empty_vec;

    voq_buffer #(.NUM_OUT(NO), .DEPTH(DP), .LEN_W(LW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_eop(in_eop), .in_dest(in_dest), .in_len(in_len), .in_data(in_data),
        .deq_valid(deq_valid), .deq_sel(deq_sel), .out_valid(out_valid),
        .out_sop(out_sop), .out_len(out_len), .out_data(out_data),
        .deq_err(deq_err), .occ_flat(occ_flat), .empty_vec(empty_vec)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    int seq      = 1;

    // bench model: per-queue ring of {sop, len, data}
    logic [1+LW+DW-1:0] mq [NO][MQ];
    int hd [NO];
    int tl [NO];
    int ec [NO];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_counts(input string tag);
        for (int q = 0; q < NO; q++) begin
            int a;
            a = int'(occ_flat[q*CNT_W +: CNT_W]);
            chk(a == ec[q], tag, a, ec[q]);
            chk(empty_vec[q] == (ec[q] == 0), {tag, " R9 empty"}, int'(empty_vec[q]), int'(ec[q] == 0));
        end
    endtask

    task automatic push_model(input int d, input bit s, input int len, input int data);
        mq[d][tl[d]] = {s, LW'(len), DW'(data)};
        tl[d] = (tl[d] + 1) % MQ;
        ec[d]++;
    endtask

    // drives one packet; first cell to d, later cells carry in_dest=alt
    task automatic send_pkt(input int d, input int len, input int ncells, input int alt, input string tag);
        bit acc;
        acc = (len >= 1) && (len <= DP - ec[d]);
        for (int i = 0; i < ncells; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_sop   = (i == 0);
            in_eop   = (i == ncells - 1);
            in_dest  = DEST_W'((i == 0) ? d : alt);
            in_len   = LW'(len);
            in_data  = DW'(seq);
            if (acc) push_model(d, (i == 0), len, seq);
            seq++;
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_sop   = 1'b0;
        in_eop   = 1'b0;
        check_counts(tag);
    endtask

    task automatic deq_one(input int d, input string tag);
        logic [1+LW+DW-1:0] e;
        bit was_empty;
        was_empty = (ec[d] == 0);
        e = mq[d][hd[d]];
        @(negedge clk);
        deq_valid = 1'b1;
        deq_sel   = DEST_W'(d);
        @(negedge clk);
        deq_valid = 1'b0;
        if (was_empty) begin
            chk(deq_err == 1'b1, {tag, " R7 err"}, int'(deq_err), 1);
            chk(out_valid == 1'b0, {tag, " R7 valid"}, int'(out_valid), 0);
        end else begin
            hd[d] = (hd[d] + 1) % MQ;
            ec[d]--;
            chk(out_valid == 1'b1 && deq_err == 1'b0, {tag, " R6 valid"}, int'(out_valid), 1);
            chk({out_sop, out_len, out_data} == e, {tag, " R6 cell"},
                int'({out_sop, out_len, out_data}), int'(e));
        end
        check_counts(tag);
    endtask

    task automatic drain(input int d, input string tag);
        while (ec[d] > 0) deq_one(d, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int q = 0; q < NO; q++) begin
            hd[q] = 0; tl[q] = 0; ec[q] = 0;
        end
        rst_n = 1'b0; in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
        in_dest = '0; in_len = '0; in_data = '0; deq_valid = 1'b0; deq_sel = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check_counts("R1 reset");
        chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        chk(deq_err == 1'b0, "R1 deq_err", int'(deq_err), 0);

        // R7 dequeue of every empty queue
        for (int d = 0; d < NO; d++) deq_one(d, "R7 empty deq");

        // R2/R3 length sweep into empty queues, including 0 and DP+1
        for (int d = 0; d < NO; d++) begin
            send_pkt(d, 0, 1, d, "R2 len0 drop");
            for (int len = 1; len <= DP + 1; len++) begin
                send_pkt(d, len, len, d, "R2 sweep");
                drain(d, "R6 sweep drain");
            end
        end

        // R5/R3 fill sequence on each queue with the others partly loaded
        for (int d = 0; d < NO; d++) begin
            int o;
            o = (d + 1) % NO;
            send_pkt(o, 2, 2, o, "R5 neighbour");
            send_pkt(d, 3, 3, d, "R2 fill3");
            send_pkt(d, 6, 6, d, "R3 reject6");
            send_pkt(d, 5, 5, d, "R5 fill5 full");
            send_pkt(d, 1, 1, d, "R3 reject full");
            send_pkt(o, 6, 6, o, "R5 other admits");
            drain(d, "R6 fill drain");
            drain(o, "R6 neighbour drain");
        end

        // R4 continuation cells carry another destination
        send_pkt(1, 4, 4, 3, "R4 latched dest");
        send_pkt(2, 3, 3, 0, "R4 latched dest");
        drain(1, "R4 drain");
        drain(2, "R4 drain");

        // R3 rejected packet whose later cells name a queue with room
        send_pkt(0, DP + 2, DP + 2, 1, "R3 reject alt");

        // R10 stray continuation cells in IDLE
        for (int d = 0; d < NO; d++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sop = 1'b0; in_eop = (d % 2 == 0);
            in_dest = DEST_W'(d); in_len = LW'(1); in_data = DW'(seq); seq++;
            @(negedge clk);
            in_valid = 1'b0; in_eop = 1'b0;
            check_counts("R10 stray");
        end

        // R8 concurrent enqueue and dequeue on the same queue
        for (int d = 0; d < NO; d++) begin
            logic [1+LW+DW-1:0] e;
            send_pkt(d, 2, 2, d, "R8 preload");
            e = mq[d][hd[d]];
            @(negedge clk);
            in_valid = 1'b1; in_sop = 1'b1; in_eop = 1'b1;
            in_dest = DEST_W'(d); in_len = LW'(1); in_data = DW'(seq);
            deq_valid = 1'b1; deq_sel = DEST_W'(d);
            hd[d] = (hd[d] + 1) % MQ; ec[d]--;
            push_model(d, 1'b1, 1, seq); seq++;
            @(negedge clk);
            in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; deq_valid = 1'b0;
            chk(out_valid == 1'b1, "R8 valid", int'(out_valid), 1);
            chk({out_sop, out_len, out_data} == e, "R8 cell",
                int'({out_sop, out_len, out_data}), int'(e));
            check_counts("R8 count held");
            drain(d, "R8 drain");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule